// File: doc/BRIEF.md
# Direct-Mapped Address Translator with Privilege Checks

This block turns a virtual address into a physical address in the same cycle as the request. It keeps two independent direct-mapped translation tables, one for instruction fetches and one for data accesses. Each request carries a virtual address, an access kind, the privilege level and one translation-enable flag per side. The answer holds a physical address, the rights the selected entry grants, and a result code that says whether the access may go ahead, missed the table, or broke a permission.

Software-style loading happens through a write port. The port chooses the side, chooses the tag word or the mapping word of an entry, and gives the entry index. When a side's enable is low, requests on that side get an identity mapping with every right granted. A synchronous reset invalidates every entry on both sides. Page walking, set associativity and fault vectoring belong to the logic around this block.

Top module: `tlb_xlate`

## Requirements
- R1: The entry index is `req_va[18:13]` and the tag is `req_va[31:19]`. A lookup compares the tag with bits [31:19] of the entry's tag word. A valid entry whose tag differs gives result code 2'b01 (miss).
- R2: Bit 0 of the tag word is the entry's valid flag. A lookup that lands on an entry with this flag clear gives 2'b01 (miss), even when the tag matches.
- R3: On a hit, `rsp_pa` is bits [31:13] of the entry's mapping word followed by `req_va[12:0]`, and the result code is 2'b00 (match).
- R4: Mapping-word bits [5:0] are the permissions: [0] supervisor read, [1] supervisor write, [2] supervisor execute, [3] user read, [4] user write, [5] user execute. `req_super`=1 selects the supervisor bits. `rsp_rights` is {exec, write, read}. A fetch reports only exec, and a data access reports only read and write.
- R5: A fetch that hits an entry without the selected execute right gives 2'b10 (protection).
- R6: Access kinds are 2'b00 fetch, 2'b01 load, 2'b10 store, and 2'b11, which behaves as a load. A load without read right, or a store without write right, gives 2'b10.
- R7: A fetch uses the instruction side and `imu_en`. Every other kind uses the data side and `dmu_en`. When the selected enable is 0, `rsp_pa` equals `req_va`, `rsp_rights` is 3'b111 and the code is 2'b00.
- R8: A write takes effect at the clock edge where `wr_en` is 1. `wr_side` selects the side (0 instruction, 1 data) and `wr_word` selects the word (0 tag word, 1 mapping word). The other side and the other word are left unchanged.
- R9: A synchronous reset clears every valid flag on both sides, so later enabled lookups miss until entries are written again.
- R10: The code 2'b11 never appears. A miss reports `rsp_rights`=0 and `rsp_pa`=0.
- R11: The response depends only on the current request inputs and the stored table, and it is valid in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | 0 instruction table, 1 data table |
| wr_word | input | 1 | 0 tag word, 1 mapping word |
| wr_idx | input | 6 | Entry index to write |
| wr_data | input | 32 | Word to store |
| req_va | input | 32 | Virtual address of the request |
| req_kind | input | 2 | Access kind |
| req_super | input | 1 | 1 for supervisor privilege |
| imu_en | input | 1 | Instruction translation enable |
| dmu_en | input | 1 | Data translation enable |
| rsp_pa | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted rights {exec, write, read} |
| rsp_code | output | 2 | 00 match, 01 miss, 10 protection |

## Verification
The bench targets index 0 and index 63, tag mismatches on an occupied slot, an entry whose valid flag was cleared while its mapping stayed in place, and writes to one side followed by probes of the same slot on the other side. A design that drops the valid bit would translate stale entries, and one that shares storage across sides would answer fetches from data mappings. The bench also crosses privilege with kind, including the load-like fourth kind and entries that grant only user rights. A design that swapped the supervisor and user selection, or treated a store as a load, would report a match where a protection code is due. A design that lets the enable of the wrong side drive the identity bypass would return translated addresses with the bypass flag low.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        RES_MATCH = 2'b00,
        RES_MISS  = 2'b01,
        RES_PROT  = 2'b10
    } res_code_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_ALT   = 2'b11
    } acc_kind_e;

    localparam int PERM_W = 6;
    localparam int PB_SR  = 0;
    localparam int PB_SW  = 1;
    localparam int PB_SX  = 2;
    localparam int PB_UR  = 3;
    localparam int PB_UW  = 4;
    localparam int PB_UX  = 5;

    localparam int SIDE_I = 0;
    localparam int SIDE_D = 1;
    localparam int N_SIDE = 2;

endpackage

// File: rtl/tlb_bank.sv
module tlb_bank #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 13,
    parameter int PPN_W = 19
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      wr_word,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_valid,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic [PPN_W-1:0]          wr_ppn,
    input  logic [tlb_pkg::PERM_W-1:0] wr_perm,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic                      rd_valid,
    output logic [TAG_W-1:0]          rd_tag,
    output logic [PPN_W-1:0]          rd_ppn,
    output logic [tlb_pkg::PERM_W-1:0] rd_perm
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]            valid_q;
    logic [TAG_W-1:0]            tag_q  [DEPTH];
    logic [PPN_W-1:0]            ppn_q  [DEPTH];
    logic [tlb_pkg::PERM_W-1:0]  perm_q [DEPTH];

    // Only the valid flags are reset; payload words need no clearing.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en && !wr_word) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !wr_word) begin
            tag_q[wr_idx] <= wr_tag;
        end
        if (wr_en && wr_word) begin
            ppn_q[wr_idx]  <= wr_ppn;
            perm_q[wr_idx] <= wr_perm;
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_ppn   = ppn_q[rd_idx];
        rd_perm  = perm_q[rd_idx];
    end

endmodule

// File: rtl/tlb_judge.sv
module tlb_judge
    import tlb_pkg::*;
(
    input  logic              hit_valid,
    input  logic              tag_eq,
    input  logic              is_fetch,
    input  logic              is_store,
    input  logic              is_super,
    input  logic [PERM_W-1:0] perm,
    output res_code_e         code,
    output logic [2:0]        rights
);
    logic can_r, can_w, can_x, needed;
    logic [2:0] granted;

    always_comb begin
        can_r = is_super ? perm[PB_SR] : perm[PB_UR];
        can_w = is_super ? perm[PB_SW] : perm[PB_UW];
        can_x = is_super ? perm[PB_SX] : perm[PB_UX];

        if (is_fetch) begin
            granted = {can_x, 2'b00};
            needed  = can_x;
        end else begin
            granted = {1'b0, can_w, can_r};
            needed  = is_store ? can_w : can_r;
        end

        if (!hit_valid || !tag_eq) begin
            code   = RES_MISS;
            rights = 3'b000;
        end else if (!needed) begin
            code   = RES_PROT;
            rights = granted;
        end else begin
            code   = RES_MATCH;
            rights = granted;
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PG_BITS = 13,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_side,
    input  logic             wr_word,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_data,
    input  logic [VA_W-1:0]  req_va,
    input  logic [1:0]       req_kind,
    input  logic             req_super,
    input  logic             imu_en,
    input  logic             dmu_en,
    output logic [VA_W-1:0]  rsp_pa,
    output logic [2:0]       rsp_rights,
    output logic [1:0]       rsp_code
);
    localparam int VPN_W = VA_W - PG_BITS;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PPN_W = VPN_W;

    // Field extraction from the write word
    logic              f_valid;
    logic [TAG_W-1:0]  f_tag;
    logic [PPN_W-1:0]  f_ppn;
    logic [PERM_W-1:0] f_perm;
    logic              unused_mid;

    assign f_valid    = wr_data[0];
    assign f_tag      = wr_data[VA_W-1 -: TAG_W];
    assign f_ppn      = wr_data[VA_W-1 -: PPN_W];
    assign f_perm     = wr_data[PERM_W-1:0];
    assign unused_mid = ^wr_data[PG_BITS-1:PERM_W];

    // Lookup fields from the request
    logic [IDX_W-1:0]  l_idx;
    logic [TAG_W-1:0]  l_tag;
    assign l_idx = req_va[PG_BITS +: IDX_W];
    assign l_tag = req_va[VA_W-1 -: TAG_W];

    logic [N_SIDE-1:0]                  bk_valid;
    logic [N_SIDE-1:0][TAG_W-1:0]       bk_tag;
    logic [N_SIDE-1:0][PPN_W-1:0]       bk_ppn;
    logic [N_SIDE-1:0][PERM_W-1:0]      bk_perm;

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        logic side_we;
        assign side_we = wr_en && (wr_side == g[0]);

        tlb_bank #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .PPN_W (PPN_W)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (side_we),
            .wr_word  (wr_word),
            .wr_idx   (wr_idx),
            .wr_valid (f_valid),
            .wr_tag   (f_tag),
            .wr_ppn   (f_ppn),
            .wr_perm  (f_perm),
            .rd_idx   (l_idx),
            .rd_valid (bk_valid[g]),
            .rd_tag   (bk_tag[g]),
            .rd_ppn   (bk_ppn[g]),
            .rd_perm  (bk_perm[g])
        );
    end

    // Side selection
    logic is_fetch, is_store, side, xl_on;
    assign is_fetch = (req_kind == ACC_FETCH);
    assign is_store = (req_kind == ACC_STORE);
    assign side     = is_fetch ? 1'b0 : 1'b1;
    assign xl_on    = is_fetch ? imu_en : dmu_en;

    res_code_e  j_code;
    logic [2:0] j_rights;

    tlb_judge u_judge (
        .hit_valid (bk_valid[side]),
        .tag_eq    (bk_tag[side] == l_tag),
        .is_fetch  (is_fetch),
        .is_store  (is_store),
        .is_super  (req_super),
        .perm      (bk_perm[side]),
        .code      (j_code),
        .rights    (j_rights)
    );

    always_comb begin
        if (!xl_on) begin
            rsp_pa     = req_va;
            rsp_rights = 3'b111;
            rsp_code   = RES_MATCH;
        end else begin
            rsp_code   = j_code;
            rsp_rights = j_rights;
            rsp_pa     = (j_code == RES_MISS) ? '0
                                              : {bk_ppn[side], req_va[PG_BITS-1:0]};
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VA_W    = 32,
    parameter int PG_BITS = 13
) (
    input logic            clk,
    input logic            rst,
    input logic [VA_W-1:0] req_va,
    input logic [1:0]      req_kind,
    input logic            imu_en,
    input logic            dmu_en,
    input logic [VA_W-1:0] rsp_pa,
    input logic [2:0]      rsp_rights,
    input logic [1:0]      rsp_code
);
    logic side_on;
    assign side_on = (req_kind == 2'b00) ? imu_en : dmu_en;

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_code != 2'b11);  // R10

    AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (rst)
        !side_on |-> (rsp_pa == req_va && rsp_rights == 3'b111 && rsp_code == 2'b00));  // R7

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (side_on && rsp_code == 2'b01) |-> (rsp_rights == 3'b000 && rsp_pa == '0));  // R10

    AST_FETCH_EXEC: assert property (@(posedge clk) disable iff (rst)
        (side_on && req_kind == 2'b00 && rsp_code == 2'b00) |-> rsp_rights == 3'b100);  // R5

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (side_on && req_kind == 2'b10 && rsp_code == 2'b00) |-> rsp_rights[1]);  // R6

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (side_on && rsp_code != 2'b01) |-> rsp_pa[PG_BITS-1:0] == req_va[PG_BITS-1:0]);  // R3

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && side_on) |-> rsp_code == 2'b01);  // R9

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VA_W    (VA_W),
    .PG_BITS (PG_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_va     (req_va),
    .req_kind   (req_kind),
    .imu_en     (imu_en),
    .dmu_en     (dmu_en),
    .rsp_pa     (rsp_pa),
    .rsp_rights (rsp_rights),
    .rsp_code   (rsp_code)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_side = 1'b0, wr_word = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0, imu_en = 1'b0, dmu_en = 1'b0;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_rights;
    logic [1:0]  rsp_code;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_side(wr_side), .wr_word(wr_word),
        .wr_idx(wr_idx), .wr_data(wr_data), .req_va(req_va), .req_kind(req_kind),
        .req_super(req_super), .imu_en(imu_en), .dmu_en(dmu_en),
        .rsp_pa(rsp_pa), .rsp_rights(rsp_rights), .rsp_code(rsp_code)
    );

    typedef struct {
        logic [31:0] pa;
        logic [2:0]  rights;
        logic [1:0]  code;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Shadow of what the bench has written
    logic        sh_v    [2][64];
    logic [12:0] sh_tag  [2][64];
    logic [18:0] sh_ppn  [2][64];
    logic [5:0]  sh_perm [2][64];

    function automatic logic [31:0] va_of(input logic [12:0] t, input logic [5:0] i,
                                          input logic [12:0] off);
        return {t, i, off};
    endfunction

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] k,
                                   input logic sup, input logic ie, input logic de,
                                   input string nm);
        exp_t e;
        int s;
        logic [5:0] ix;
        logic r, w, x, need;
        e.tag = nm;
        s  = (k == 2'b00) ? 0 : 1;
        ix = va[18:13];
        if ((s == 0 && !ie) || (s == 1 && !de)) begin
            e.pa = va; e.rights = 3'b111; e.code = 2'b00;
            return e;
        end
        if (!sh_v[s][ix] || sh_tag[s][ix] != va[31:19]) begin
            e.pa = '0; e.rights = 3'b000; e.code = 2'b01;
            return e;
        end
        r = sup ? sh_perm[s][ix][0] : sh_perm[s][ix][3];
        w = sup ? sh_perm[s][ix][1] : sh_perm[s][ix][4];
        x = sup ? sh_perm[s][ix][2] : sh_perm[s][ix][5];
        if (s == 0) begin e.rights = {x, 2'b00}; need = x; end
        else begin e.rights = {1'b0, w, r}; need = (k == 2'b10) ? w : r; end
        e.pa   = {sh_ppn[s][ix], va[12:0]};
        e.code = need ? 2'b00 : 2'b10;
        return e;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 64; i++) sh_v[s][i] = 1'b0;
    endtask

    task automatic put(input logic side, input logic word, input logic [5:0] idx,
                       input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_side = side; wr_word = word; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!word) begin sh_v[side][idx] = d[0]; sh_tag[side][idx] = d[31:19]; end
        else begin sh_ppn[side][idx] = d[31:13]; sh_perm[side][idx] = d[5:0]; end
    endtask

    // Driver: applies one request and queues the expected answer
    task automatic look(input logic [31:0] va, input logic [1:0] k, input logic sup,
                        input logic ie, input logic de, input string nm);
        @(negedge clk);
        req_va = va; req_kind = k; req_super = sup; imu_en = ie; dmu_en = de;
        sb.push_back(model(va, k, sup, ie, de, nm));
    endtask

    // Monitor: compares in the same cycle, away from the clock edge (R11)
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (rsp_pa !== e.pa || rsp_rights !== e.rights || rsp_code !== e.code) begin
                    n_fail++;
                    $display("FAIL %s actual pa=%h rights=%b code=%b expected pa=%h rights=%b code=%b",
                             e.tag, rsp_pa, rsp_rights, rsp_code, e.pa, e.rights, e.code);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R9: empty tables after reset
        look(va_of(13'h0A5, 6'd5, 13'h0010), 2'b00, 1'b1, 1'b1, 1'b1, "R9 fetch after reset");
        look(va_of(13'h0A5, 6'd5, 13'h0010), 2'b01, 1'b1, 1'b1, 1'b1, "R9 load after reset");
        // R7: bypass per side
        look(32'hDEAD_BEEF, 2'b00, 1'b0, 1'b0, 1'b1, "R7 fetch bypass");
        look(32'h1234_5678, 2'b10, 1'b0, 1'b1, 1'b0, "R7 store bypass");
        look(32'h1234_5678, 2'b00, 1'b0, 1'b1, 1'b0, "R7 fetch uses imu_en");
        // Instruction entry at index 5, supervisor execute only
        put(1'b0, 1'b0, 6'd5, {13'h0A5, 18'd0, 1'b1});
        put(1'b0, 1'b1, 6'd5, {19'h12345, 7'd0, 6'b000100});
        look(va_of(13'h0A5, 6'd5, 13'h1ABC), 2'b00, 1'b1, 1'b1, 1'b1, "R3 R4 fetch hit");
        look(va_of(13'h0A5, 6'd5, 13'h1ABC), 2'b00, 1'b0, 1'b1, 1'b1, "R5 user fetch no exec");
        look(va_of(13'h0A4, 6'd5, 13'h0000), 2'b00, 1'b1, 1'b1, 1'b1, "R1 tag mismatch");
        // Data entry at index 63
        put(1'b1, 1'b0, 6'd63, {13'h1FFF, 18'd0, 1'b1});
        put(1'b1, 1'b1, 6'd63, {19'h7FFFF, 7'd0, 6'b001011});
        look(va_of(13'h1FFF, 6'd63, 13'h1FFF), 2'b01, 1'b0, 1'b1, 1'b1, "R4 user load idx63");
        look(va_of(13'h1FFF, 6'd63, 13'h0004), 2'b10, 1'b0, 1'b1, 1'b1, "R6 user store denied");
        look(va_of(13'h1FFF, 6'd63, 13'h0004), 2'b10, 1'b1, 1'b1, 1'b1, "R6 super store ok");
        look(va_of(13'h1FFF, 6'd63, 13'h0008), 2'b11, 1'b0, 1'b1, 1'b1, "R6 kind3 as load");
        // R8: sides are separate
        look(va_of(13'h1FFF, 6'd63, 13'h0000), 2'b00, 1'b1, 1'b1, 1'b1, "R8 inst idx63 empty");
        look(va_of(13'h0A5, 6'd5, 13'h0000), 2'b01, 1'b1, 1'b1, 1'b1, "R8 data idx5 empty");
        // R2: valid flag cleared, mapping kept
        put(1'b0, 1'b0, 6'd5, {13'h0A5, 18'd0, 1'b0});
        look(va_of(13'h0A5, 6'd5, 13'h0020), 2'b00, 1'b1, 1'b1, 1'b1, "R2 invalid entry");
        put(1'b0, 1'b0, 6'd5, {13'h0A5, 18'd0, 1'b1});
        look(va_of(13'h0A5, 6'd5, 13'h0020), 2'b00, 1'b1, 1'b1, 1'b1, "R8 mapping word kept");
        // Data entry at index 0, user-only rights
        put(1'b1, 1'b0, 6'd0, {13'h0000, 18'd0, 1'b1});
        put(1'b1, 1'b1, 6'd0, {19'h00001, 7'd0, 6'b111000});
        look(va_of(13'h0000, 6'd0, 13'h0123), 2'b01, 1'b1, 1'b1, 1'b1, "R6 super load no read");
        look(va_of(13'h0000, 6'd0, 13'h0123), 2'b10, 1'b0, 1'b1, 1'b1, "R4 user store idx0");
        // R9: reset again
        do_reset();
        look(va_of(13'h0A5, 6'd5, 13'h0020), 2'b00, 1'b1, 1'b1, 1'b1, "R9 cleared inst");
        look(va_of(13'h0000, 6'd0, 13'h0123), 2'b10, 1'b0, 1'b1, 1'b1, "R9 cleared data");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R11 queue actual=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule